// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This block is a register-mapped timer with a parameterised number of channels. Two is the small build and four is the large one. Each channel holds a 64-bit down-counter, a 64-bit interval register and a control word. The control word selects enable, a load request, a power-of-two clock prescaler and either periodic or one-shot operation. A shared interrupt-enable word and a shared sticky status word cover all channels. Each channel raises its own interrupt line.

Software programs the interval, then writes the control word with enable and the load request set. The counter then falls by one on every prescaled tick. On expiry, a periodic channel reloads from the interval and a one-shot channel parks at zero and turns itself off. Software clears a status flag by writing a one to it. A channel that is disabled keeps counting for a fixed number of clock cycles before it holds, so software must leave a short gap before it reprograms. The 64-bit count is read as two 32-bit words. Reading the low word freezes a copy of the high word, so a pair of reads always gives a consistent value.

Top module: `evt_tmr`

## Requirements
- R1: After reset every readable register reads 0 and every interrupt line is low.
- R2: The interrupt-enable word is at 0x00 and the status word at 0x04, with bit n belonging to channel n. Channel n has its control word at 0x20*n+0x10, interval low and high at +0x14 and +0x18, and count low and high at +0x1C and +0x20. Interval words read back what was written. Read data appears on `bus_rdata` in the cycle after the one in which `bus_rd` is sampled.
- R3: Control bit 0 is enable, bit 1 is the load request, bits 6:4 are the prescaler select and bit 7 selects one-shot. The load bit always reads 0. A control write with bits 0 and 1 both set copies the 64-bit interval into the counter.
- R4: A running channel with select s decrements once every 2^s clock cycles. The first decrement comes 2^s cycles after the control write edge.
- R5: In periodic mode, a tick that finds the count at 1 or 0 reloads the interval and sets the status bit. With interval N the count reads N, N-1, ... 1 and then N again.
- R6: In one-shot mode the expiring tick sets the status bit, leaves the count at 0 and clears the enable bit.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it. An expiry in the same cycle as a clear wins.
- R8: Interrupt line n is high exactly when status bit n and enable bit n are both set.
- R9: After a control write with enable clear, a running channel counts for STOP_DLY (default 2) more cycles and then holds its value.
- R10: Reading count low latches the counter's high word. A later read of count high returns that latched word, even if the counter has since borrowed across the word boundary.
- R11: Addresses outside the map (such as 0x08, word offsets 0x14 and above inside a channel slot, and slots of channels that are not built) read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
The bench counts every result from the clock edge that samples the stimulus. Read data is due one edge after `bus_rd`. A count read k edges after the loading control write returns the interval minus floor((k-1)/2^s). A periodic expiry with interval N raises status and the interrupt line N edges after the write. A disable lets the count drop for STOP_DLY edges beyond the write edge. Inputs change and outputs are sampled on the falling edge, and each expected value is derived from this edge count. The prescaler sweep covers all eight select values and read offsets placed just before, at and after tick boundaries.

// File: rtl/evt_tmr_pkg.sv
// Package evt_tmr_pkg
// Shared register offsets, word selectors and control bit positions for the
// multi-channel event timer. Assumes a byte-addressed 32-bit register bus.
package evt_tmr_pkg;

    localparam int IE_OFS    = 'h00;  // interrupt enable word
    localparam int ST_OFS    = 'h04;  // sticky status word
    localparam int CH_BASE   = 'h10;  // first channel control word
    localparam int CH_SHIFT  = 5;     // 0x20-byte channel slot

    localparam int CTL_EN    = 0;
    localparam int CTL_LOAD  = 1;
    localparam int CTL_PSEL  = 4;     // lsb of prescaler select
    localparam int CTL_OSH   = 7;

    // word selector inside a channel slot, in address order
    typedef enum logic [2:0] {
        W_CTL    = 3'd0,
        W_IVL_LO = 3'd1,
        W_IVL_HI = 3'd2,
        W_CNT_LO = 3'd3,
        W_CNT_HI = 3'd4
    } word_e;

endpackage

// File: rtl/evt_tmr_presc.sv
// Module evt_tmr_presc
// Per-channel prescaler: produces a one-cycle tick every 2^sel cycles while
// run is high. clr restarts the phase so the first tick after a control
// write lands exactly 2^sel cycles later. Assumes sel only changes with clr.
module evt_tmr_presc #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PC_W = (1 << SEL_W) - 1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] lim;

    // terminal value of the phase counter for this select
    always_comb begin
        lim  = PC_W'((32'd1 << sel) - 32'd1);
        tick = run && (pc_q == lim);
    end

    // phase counter: restarts on clr or tick, advances while running
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (clr)    pc_q <= '0;
        else if (tick)   pc_q <= '0;
        else if (run)    pc_q <= pc_q + 1'b1;
    end

    // R4
    presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (sel != '0) && !clr) |=> !tick);

endmodule

// File: rtl/evt_tmr_chan.sv
// Module evt_tmr_chan
// One timer channel: control word, 64-bit interval, 64-bit down-counter,
// high-word read shadow and the delayed stop after disable. Emits a one-cycle
// expire pulse; status and interrupt masking live in the parent.
// Assumes at most one of the write/read strobes is active per cycle.
module evt_tmr_chan
    import evt_tmr_pkg::*;
#(
    parameter int DW       = 32,
    parameter int SEL_W    = 3,
    parameter int STOP_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          ilo_we,
    input  logic          ihi_we,
    input  logic          clo_re,
    input  logic [DW-1:0] wdata,
    input  logic [2:0]    sub,
    output logic [DW-1:0] rword,
    output logic          expire
);
    localparam int CNT_W = 2 * DW;
    localparam int DLY_W = $clog2(STOP_DLY + 1) < 1 ? 1 : $clog2(STOP_DLY + 1);

    logic             en_q, osh_q, run_q;
    logic [SEL_W-1:0] psel_q;
    logic [CNT_W-1:0] ivl_q, cnt_q;
    logic [DW-1:0]    shd_q;
    logic [DLY_W-1:0] dly_q;
    logic             tick, load, w_en;

    evt_tmr_presc #(.SEL_W(SEL_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run_q),
        .clr  (ctl_we),
        .sel  (psel_q),
        .tick (tick)
    );

    // decode of a control write and the expiry condition
    always_comb begin
        w_en   = wdata[CTL_EN];
        load   = ctl_we && w_en && wdata[CTL_LOAD];
        expire = tick && !load && (cnt_q <= CNT_W'(1));
    end

    // control fields, run state and disable delay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            osh_q  <= 1'b0;
            psel_q <= '0;
            run_q  <= 1'b0;
            dly_q  <= '0;
        end else if (ctl_we) begin
            en_q   <= w_en;
            osh_q  <= wdata[CTL_OSH];
            psel_q <= wdata[CTL_PSEL +: SEL_W];
            if (w_en) begin
                run_q <= 1'b1;
                dly_q <= '0;
            end else if (run_q && dly_q == '0) begin
                if (STOP_DLY == 0) run_q <= 1'b0;
                else               dly_q <= DLY_W'(STOP_DLY);
            end
        end else if (expire && osh_q) begin
            en_q  <= 1'b0;
            run_q <= 1'b0;
            dly_q <= '0;
        end else if (dly_q != '0) begin
            dly_q <= dly_q - 1'b1;
            if (dly_q == DLY_W'(1)) run_q <= 1'b0;
        end
    end

    // interval register, written one half at a time
    always_ff @(posedge clk) begin
        if (!rst_n)      ivl_q <= '0;
        else if (ilo_we) ivl_q[DW-1:0]     <= wdata;
        else if (ihi_we) ivl_q[CNT_W-1:DW] <= wdata;
    end

    // down-counter: load, expire (reload or park) or decrement
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load)   cnt_q <= ivl_q;
        else if (expire) cnt_q <= osh_q ? '0 : ivl_q;
        else if (tick)   cnt_q <= cnt_q - 1'b1;
    end

    // high-word shadow captured by a low-word read
    always_ff @(posedge clk) begin
        if (!rst_n)      shd_q <= '0;
        else if (clo_re) shd_q <= cnt_q[CNT_W-1:DW];
    end

    // read word selection within the channel slot
    always_comb begin
        rword = '0;
        case (word_e'(sub))
            W_CTL:    begin
                rword[CTL_EN]               = en_q;
                rword[CTL_PSEL +: SEL_W]    = psel_q;
                rword[CTL_OSH]              = osh_q;
            end
            W_IVL_LO: rword = ivl_q[DW-1:0];
            W_IVL_HI: rword = ivl_q[CNT_W-1:DW];
            W_CNT_LO: rword = cnt_q[DW-1:0];
            W_CNT_HI: rword = shd_q;
            default:  rword = '0;
        endcase
    end

    // R4
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctl_we && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !osh_q) |=> (cnt_q == $past(ivl_q)));
    // R6
    oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && osh_q) |=> (!run_q && !en_q && cnt_q == '0));
    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !ctl_we) |=> $stable(cnt_q));
    // R9
    stop_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_q == DLY_W'(1) && !ctl_we) |=> !run_q);

endmodule

// File: rtl/evt_tmr.sv
// Module evt_tmr
// Multi-channel down-counting event timer with a simple synchronous register
// bus. Decodes the address map, holds the shared interrupt-enable and sticky
// status words, registers read data and drives one interrupt per channel.
// Assumes bus_wr and bus_rd are never active in the same cycle.
module evt_tmr
    import evt_tmr_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int DW       = 32,
    parameter int AW       = 8,
    parameter int SEL_W    = 3,
    parameter int STOP_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int CIW = AW - CH_SHIFT;

    logic [AW-1:0]     off;
    logic [CIW-1:0]    ch_idx;
    logic [2:0]        sub;
    logic              in_win, hit_ie, hit_st;
    logic [NUM_CH-1:0] ch_hit, ch_exp;
    logic [DW-1:0]     ch_rword [NUM_CH];
    logic [NUM_CH-1:0] ie_q, stat_q, st_clr;
    logic [DW-1:0]     rd_val;

    // address decode into shared words and channel slots
    always_comb begin
        off    = bus_addr - AW'(CH_BASE);
        ch_idx = off[AW-1:CH_SHIFT];
        sub    = off[4:2];
        hit_ie = (bus_addr == AW'(IE_OFS));
        hit_st = (bus_addr == AW'(ST_OFS));
        in_win = (bus_addr >= AW'(CH_BASE)) && (off[1:0] == 2'b00)
                 && (sub <= 3'(W_CNT_HI));
    end

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            assign ch_hit[i] = in_win && (ch_idx == CIW'(i));

            evt_tmr_chan #(
                .DW      (DW),
                .SEL_W   (SEL_W),
                .STOP_DLY(STOP_DLY)
            ) u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .ctl_we(bus_wr && ch_hit[i] && sub == 3'(W_CTL)),
                .ilo_we(bus_wr && ch_hit[i] && sub == 3'(W_IVL_LO)),
                .ihi_we(bus_wr && ch_hit[i] && sub == 3'(W_IVL_HI)),
                .clo_re(bus_rd && ch_hit[i] && sub == 3'(W_CNT_LO)),
                .wdata (bus_wdata),
                .sub   (sub),
                .rword (ch_rword[i]),
                .expire(ch_exp[i])
            );

            // R7
            st_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(stat_q[i]) |-> $past(ch_exp[i]));
            // R7
            st_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && hit_st && bus_wdata[i] && !ch_exp[i]) |=> !stat_q[i]);
            // R8
            irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !ie_q[i] |-> !irq[i]);
        end
    endgenerate

    // write-one-to-clear mask for the status word
    always_comb st_clr = (bus_wr && hit_st) ? bus_wdata[NUM_CH-1:0] : '0;

    // interrupt enable word
    always_ff @(posedge clk) begin
        if (!rst_n)                ie_q <= '0;
        else if (bus_wr && hit_ie) ie_q <= bus_wdata[NUM_CH-1:0];
    end

    // sticky status: expiry sets, written ones clear, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~st_clr) | ch_exp;
    end

    // read multiplexer over shared words and channel slots
    always_comb begin
        rd_val = '0;
        if (hit_ie)      rd_val = DW'(ie_q);
        else if (hit_st) rd_val = DW'(stat_q);
        for (int i = 0; i < NUM_CH; i++)
            if (ch_hit[i]) rd_val = ch_rword[i];
    end

    // registered read data, updated only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    assign irq = stat_q & ie_q;

endmodule

// File: tb/evt_tmr_bench.sv
// Bench for evt_tmr (NUM_CH=2). Inputs change and outputs are sampled on the
// falling clock edge; every bus task consumes exactly one rising edge.
module evt_tmr_bench;
    localparam int NUM_CH   = 2;
    localparam int STOP_DLY = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    evt_tmr #(.NUM_CH(NUM_CH), .STOP_DLY(STOP_DLY)) u_evt_tmr (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    function automatic logic [7:0] a_ctl(int n); return 8'(32'h10 + 32'h20 * n); endfunction
    function automatic logic [7:0] a_ilo(int n); return 8'(32'h14 + 32'h20 * n); endfunction
    function automatic logic [7:0] a_ihi(int n); return 8'(32'h18 + 32'h20 * n); endfunction
    function automatic logic [7:0] a_clo(int n); return 8'(32'h1C + 32'h20 * n); endfunction
    function automatic logic [7:0] a_chi(int n); return 8'(32'h20 + 32'h20 * n); endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        chk("R1 irq", {30'd0, irq}, 32'd0);
        rd(8'h00, d); chk("R1 ie", d, 0);
        rd(8'h04, d); chk("R1 status", d, 0);
        rd(a_ctl(0), d); chk("R1 ctl0", d, 0);
        rd(a_clo(1), d); chk("R1 cnt1", d, 0);

        // R2 / R3: map and control readback on channel 1
        wr(a_ilo(1), 32'hA5A5_0001);
        wr(a_ihi(1), 32'h0000_BEEF);
        rd(a_ilo(1), d); chk("R2 ivl lo", d, 32'hA5A5_0001);
        rd(a_ihi(1), d); chk("R2 ivl hi", d, 32'h0000_BEEF);
        wr(a_ctl(1), 32'h53);
        rd(a_ctl(1), d); chk("R3 ctl readback", d, 32'h51);
        rd(a_chi(1), d); chk("R3 load hi via shadow pre", d, 0);
        rd(a_clo(1), d); chk("R3 load lo", d, 32'hA5A5_0001);
        rd(a_chi(1), d); chk("R3 load hi", d, 32'h0000_BEEF);

        // R11: unmapped addresses
        rd(8'h08, d); chk("R11 gap", d, 0);
        rd(8'h24, d); chk("R11 slot tail", d, 0);
        wr(a_ctl(2), 32'hFF);
        rd(a_ctl(2), d); chk("R11 absent channel", d, 0);

        // R5: periodic channel 0, interval 3
        wr(8'h00, 32'h1);
        wr(a_ilo(0), 3);
        wr(a_ihi(0), 0);
        wr(a_ctl(0), 32'h03);                      // write edge W
        for (int r = 1; r <= 6; r++) begin         // read edge W+r
            rd(a_clo(0), d);
            chk("R5 periodic count", d, 32'(3 - ((r - 1) % 3)));
        end
        rd(8'h04, d); chk("R5 status set", d, 32'h1);
        chk("R8 irq0 enabled", {30'd0, irq}, 32'h1);
        wr(a_ctl(0), 32'h0);
        idle(4);

        // R7: write-one-to-clear
        wr(8'h04, 32'h0);
        rd(8'h04, d); chk("R7 write zero keeps", d, 32'h1);
        wr(8'h04, 32'h1);
        rd(8'h04, d); chk("R7 write one clears", d, 32'h0);
        chk("R7 irq low after clear", {30'd0, irq}, 0);

        // R6 / R8: one-shot channel 1, interval 5, ie bit 1 clear
        wr(a_ilo(1), 5);
        wr(a_ihi(1), 0);
        wr(a_ctl(1), 32'h83);
        idle(10);
        rd(a_clo(1), d); chk("R6 parked at zero", d, 0);
        rd(a_ctl(1), d); chk("R6 enable cleared", d, 32'h80);
        rd(8'h04, d); chk("R6 status set", d, 32'h2);
        chk("R8 masked irq", {30'd0, irq}, 0);
        wr(8'h00, 32'h3);
        chk("R8 unmasked irq", {30'd0, irq}, 32'h2);
        wr(8'h04, 32'h2);
        chk("R8 irq after clear", {30'd0, irq}, 0);

        // R9: disable delay on channel 0
        wr(a_ilo(0), 1000);
        wr(a_ctl(0), 32'h03);                      // W
        idle(4);
        wr(a_ctl(0), 32'h00);                      // E = W+5
        idle(5);
        rd(a_clo(0), d); chk("R9 stopped value", d, 32'(1000 - (5 + STOP_DLY)));
        idle(3);
        rd(a_clo(0), d); chk("R9 holds", d, 32'(1000 - (5 + STOP_DLY)));

        // R10: coherent 64-bit read across a borrow
        wr(a_ilo(0), 2);
        wr(a_ihi(0), 5);
        wr(a_ctl(0), 32'h03);                      // W
        rd(a_clo(0), d); chk("R10 low word", d, 2);           // W+1
        idle(5);
        rd(a_chi(0), d); chk("R10 shadow high", d, 5);        // W+7
        rd(a_clo(0), d); chk("R10 low after borrow", d, 32'hFFFF_FFFB); // W+8
        rd(a_chi(0), d); chk("R10 high after borrow", d, 4);
        wr(a_ctl(0), 32'h0);

        // R4: prescaler sweep on channel 1
        wr(a_ilo(1), 32'h1_0000);
        wr(a_ihi(1), 0);
        for (int s = 0; s < 8; s++) begin
            int js [4];
            js[0] = 0; js[1] = (1 << s) - 1; js[2] = 1 << s; js[3] = 3 * (1 << s) + 1;
            for (int k = 0; k < 4; k++) begin
                wr(a_ctl(1), 32'h03 | (s << 4));   // W
                idle(js[k]);
                rd(a_clo(1), d);                   // W+1+j
                chk("R4 prescaled count", d, 32'h1_0000 - 32'(js[k] >> s));
            end
        end
        wr(a_ctl(1), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule